// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which interrupt the core takes. Five sources feed it. The first is a trap that nothing can mask. Next come three restart requests with fixed vectors, called R75, R65 and R55 from highest to lowest. The last is a general request, which is served through an acknowledge cycle and has no vector. Each source has its own trigger style. The trap needs a captured rising edge and the input still held high. R75 is caught by a pending latch on its rising edge. R65 and R55 are sensed by level. The general request counts only while it is high at the decision point.

The core pulses `query` in the next-to-last clock of each instruction. On that edge the block picks the highest-priority source that is both pending and allowed. One clock later it reports the result as a one-cycle pulse, and at the same edge it clears the global enable flag. A small write port loads the three restart mask bits and can clear the R75 pending latch. Two strobes set and clear the global enable flag.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The priority order is trap, R75, R65, R55, general. `acc_src` reports the winner as 1=trap, 2=R75, 3=R65, 4=R55, 5=general and 0=none. `acc_vec` reports 0x0024 for trap, 0x003C for R75, 0x0034 for R65, 0x002C for R55, and 0 for general or none.
- R2: A pending trap is taken whatever the global enable flag and the mask bits hold.
- R3: The trap is pending only after its rising edge has been registered by a clock and while its input is still high. A fall before the query cancels it. One edge yields at most one acceptance.
- R4: A registered rising edge of R75 sets its pending latch. The latch is set even while R75 is masked or disabled, and it stays set after the input falls. It is cleared when R75 is accepted, or by a write with `cfg_clr75`=1. An edge in the same cycle as that write wins.
- R5: R65 and R55 are taken only while their inputs are high at the query edge.
- R6: `cfg_mask` bit 2 masks R75, bit 1 masks R65 and bit 0 masks R55, with 1 meaning masked. The bits load when `cfg_we`=1. The three restart sources and the general request are taken only while `ie_flag` is 1.
- R7: A decision is made only on an edge where `query`=1. Its result appears on `acc_valid`, `acc_src` and `acc_vec` for exactly the following cycle.
- R8: Taking the general request pulses `inta` and `pc_hold` together with `acc_valid`. Neither pulses for any other source.
- R9: Every acceptance clears `ie_flag`, and this overrides `ie_set` in the same cycle. Otherwise `ie_set` sets the flag and `ie_clr` clears it.
- R10: After reset, `ie_flag` is 0, all mask bits are 1, both latches are clear and every output pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_in | input | 1 | Non-maskable trap request |
| r75_in | input | 1 | Edge-latched restart request, highest restart priority |
| r65_in | input | 1 | Level restart request |
| r55_in | input | 1 | Level restart request, lowest restart priority |
| gen_in | input | 1 | General interrupt request |
| query | input | 1 | Decision point, next-to-last clock of an instruction |
| cfg_we | input | 1 | Write strobe for the mask bits and latch clear |
| cfg_mask | input | 3 | Mask bits R75/R65/R55 (bits 2/1/0), 1 masks |
| cfg_clr75 | input | 1 | With cfg_we, clears the R75 pending latch |
| ie_set | input | 1 | Sets the global enable flag |
| ie_clr | input | 1 | Clears the global enable flag |
| acc_valid | output | 1 | One-cycle acceptance pulse |
| acc_src | output | 3 | Accepted source code |
| acc_vec | output | 16 | Accepted vector address |
| inta | output | 1 | Acknowledge pulse for the general request |
| pc_hold | output | 1 | Hold the program counter for the acknowledge cycle |
| ie_flag | output | 1 | Global enable flag |

## Verification
The assertions assume that every request input is synchronous to `clk` and changes only between edges. They also assume that `ie_set` and `ie_clr` are never driven together. The bench drives all inputs on the falling edge and pulses each strobe on its own, so both assumptions always hold. The property on consecutive pulses assumes the trap input is released before it rises again. The bench lowers every request between configurations to meet this.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared source codes and vector arithmetic for the interrupt controller.
// Assumes the source index order 0..4 is trap, R75, R65, R55, general.
package irqc_pkg;

    localparam int NSRC  = 5;
    localparam int VEC_W = 16;
    localparam int SRC_W = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_GEN  = 3'd5
    } src_e;

    // Restart slot of each vectored source; zero means no vector.
    function automatic int src_slot(input int idx);
        case (idx)
            0:       return 4;
            1:       return 7;
            2:       return 6;
            3:       return 5;
            default: return 0;
        endcase
    endfunction

    // Vector address: slot times spacing plus half a spacing.
    function automatic logic [VEC_W-1:0] src_vector(input int idx, input int spacing);
        int slot;
        slot = src_slot(idx);
        if (slot == 0) return '0;
        return VEC_W'(slot * spacing + spacing / 2);
    endfunction

endpackage

// File: rtl/irqc_edge_latch.sv
// Module irqc_edge_latch
// Captures a registered rising edge of a synchronous request into a latch.
// With NEED_LEVEL set, the latch drops whenever the input falls, and the
// pending output is further qualified by the live input (trap behaviour).
// Assumes sig_in is synchronous to clk. A rise wins over clr_in.
module irqc_edge_latch #(
    parameter bit NEED_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic clr_in,
    output logic pend_out
);

    logic prev_q;
    logic armed_q;
    logic rise;

    assign rise = sig_in & ~prev_q;

    // Remember the previous sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_in;
    end

    // Arm on a rising edge; disarm on clear or, when required, on a low input.
    always_ff @(posedge clk) begin
        if (!rst_n)                              armed_q <= 1'b0;
        else if (rise)                           armed_q <= 1'b1;
        else if (clr_in || (NEED_LEVEL && !sig_in)) armed_q <= 1'b0;
    end

    generate
        if (NEED_LEVEL) begin : g_level_qual
            assign pend_out = armed_q & sig_in;
        end else begin : g_latch_only
            assign pend_out = armed_q;
        end
    endgenerate

endmodule

// File: rtl/irqc_enable_regs.sv
// Module irqc_enable_regs
// Holds the per-source restart mask bits and the global enable flag.
// Assumes ie_set and ie_clr are not raised together. Acceptance wins.
module irqc_enable_regs #(
    parameter int NMASK = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [NMASK-1:0] cfg_mask,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             accept,
    output logic [NMASK-1:0] mask_q,
    output logic             ie_q
);

    // Mask bits reset to all-masked and load from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '1;
        else if (cfg_we) mask_q <= cfg_mask;
    end

    // Global enable: acceptance clears first, then the software strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (accept) ie_q <= 1'b0;
        else if (ie_set) ie_q <= 1'b1;
        else if (ie_clr) ie_q <= 1'b0;
    end

endmodule

// File: rtl/irqc_resolver.sv
// Module irqc_resolver
// Fixed-priority one-hot grant; index 0 is the highest priority.
// Purely combinational; assumes req is already qualified.
module irqc_resolver #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);

    logic [N:0] above;

    assign above[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]   = req[i] & ~above[i];
            assign above[i+1] = above[i] | req[i];
        end
    endgenerate

    assign any = above[N];

endmodule

// File: rtl/irq_prio_ctrl.sv
// Module irq_prio_ctrl
// Top of the prioritized vectored interrupt controller. Qualifies five
// sources, resolves the winner at the query edge and registers a one-cycle
// acceptance result with source code, vector and acknowledge pulses.
// Assumes all inputs are synchronous to clk.
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int VEC_SPACING = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_in,
    input  logic             r75_in,
    input  logic             r65_in,
    input  logic             r55_in,
    input  logic             gen_in,
    input  logic             query,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_mask,
    input  logic             cfg_clr75,
    input  logic             ie_set,
    input  logic             ie_clr,
    output logic             acc_valid,
    output logic [SRC_W-1:0] acc_src,
    output logic [VEC_W-1:0] acc_vec,
    output logic             inta,
    output logic             pc_hold,
    output logic             ie_flag
);

    localparam int IDX_TRAP = 0;
    localparam int IDX_R75  = 1;
    localparam int IDX_R65  = 2;
    localparam int IDX_R55  = 3;
    localparam int IDX_GEN  = NSRC - 1;

    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  grant;
    logic             any_req;
    logic             accept;
    logic             trap_pend;
    logic             r75_pend;
    logic [2:0]       mask_q;
    logic             ie_q;
    logic [SRC_W-1:0] win_src;
    logic [VEC_W-1:0] win_vec;

    assign accept = query & any_req;

    irqc_edge_latch #(.NEED_LEVEL(1'b1)) u_trap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (trap_in),
        .clr_in   (accept & grant[IDX_TRAP]),
        .pend_out (trap_pend)
    );

    irqc_edge_latch #(.NEED_LEVEL(1'b0)) u_r75 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_in   (r75_in),
        .clr_in   ((accept & grant[IDX_R75]) | (cfg_we & cfg_clr75)),
        .pend_out (r75_pend)
    );

    irqc_enable_regs #(.NMASK(3)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_mask (cfg_mask),
        .ie_set   (ie_set),
        .ie_clr   (ie_clr),
        .accept   (accept),
        .mask_q   (mask_q),
        .ie_q     (ie_q)
    );

    // Qualify each source with its mask and the global enable.
    always_comb begin
        req           = '0;
        req[IDX_TRAP] = trap_pend;
        req[IDX_R75]  = r75_pend & ~mask_q[2] & ie_q;
        req[IDX_R65]  = r65_in   & ~mask_q[1] & ie_q;
        req[IDX_R55]  = r55_in   & ~mask_q[0] & ie_q;
        req[IDX_GEN]  = gen_in   & ie_q;
    end

    irqc_resolver #(.N(NSRC)) u_res (
        .req   (req),
        .grant (grant),
        .any   (any_req)
    );

    // Encode the one-hot grant into a source code and vector.
    always_comb begin
        win_src = SRC_NONE;
        win_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                win_src = SRC_W'(i + 1);
                win_vec = src_vector(i, VEC_SPACING);
            end
        end
    end

    // Register the acceptance result as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            acc_src   <= SRC_NONE;
            acc_vec   <= '0;
            inta      <= 1'b0;
            pc_hold   <= 1'b0;
        end else begin
            acc_valid <= accept;
            acc_src   <= accept ? win_src : SRC_NONE;
            acc_vec   <= accept ? win_vec : '0;
            inta      <= accept & grant[IDX_GEN];
            pc_hold   <= accept & grant[IDX_GEN];
        end
    end

    assign ie_flag = ie_q;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
// Module irq_prio_ctrl_chk
// Temporal checks on the controller, bound to every instance of the top.
// Assumes synchronous inputs and no overlapping ie_set/ie_clr strobes.
module irq_prio_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       query,
    input logic       trap_live,
    input logic       ie_flag,
    input logic       acc_valid,
    input logic [2:0] acc_src,
    input logic       inta,
    input logic       pc_hold
);

    AST_TRAP_ALWAYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (query && trap_live) |=> (acc_valid && acc_src == 3'd1)); // R2

    AST_NO_QUERY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !query |=> !acc_valid); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> !acc_valid); // R7

    AST_ENABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> !ie_flag); // R9

    AST_ACK_ONLY_GENERAL: assert property (@(posedge clk) disable iff (!rst_n)
        (inta || pc_hold) |-> (acc_valid && acc_src == 3'd5 && inta && pc_hold)); // R8

    AST_DISABLED_TRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (query && !ie_flag && !trap_live) |=> !acc_valid); // R6

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .query     (query),
    .trap_live (trap_pend),
    .ie_flag   (ie_flag),
    .acc_valid (acc_valid),
    .acc_src   (acc_src),
    .inta      (inta),
    .pc_hold   (pc_hold)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
module irq_prio_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_in = 0, r75_in = 0, r65_in = 0, r55_in = 0, gen_in = 0;
    logic        query = 0, cfg_we = 0, cfg_clr75 = 0, ie_set = 0, ie_clr = 0;
    logic [2:0]  cfg_mask = 3'b111;
    logic        acc_valid, inta, pc_hold, ie_flag;
    logic [2:0]  acc_src;
    logic [15:0] acc_vec;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .r75_in(r75_in),
        .r65_in(r65_in), .r55_in(r55_in), .gen_in(gen_in), .query(query),
        .cfg_we(cfg_we), .cfg_mask(cfg_mask), .cfg_clr75(cfg_clr75),
        .ie_set(ie_set), .ie_clr(ie_clr), .acc_valid(acc_valid),
        .acc_src(acc_src), .acc_vec(acc_vec), .inta(inta),
        .pc_hold(pc_hold), .ie_flag(ie_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int vec_of(input int src);
        case (src)
            1: return 16'h0024;
            2: return 16'h003C;
            3: return 16'h0034;
            4: return 16'h002C;
            default: return 0;
        endcase
    endfunction

    // Check a full acceptance result sampled in the cycle after the query.
    task automatic chk_result(input string tag, input int src);
        chk({tag, " valid"}, int'(acc_valid), int'(src != 0));
        chk({tag, " src"},   int'(acc_src), src);
        chk({tag, " vec"},   int'(acc_vec), vec_of(src));
        chk({tag, " inta R8"},    int'(inta),    int'(src == 5));
        chk({tag, " pc_hold R8"}, int'(pc_hold), int'(src == 5));
    endtask

    task automatic do_query();
        query = 1; step(); query = 0;
    endtask

    task automatic quiet();
        trap_in = 0; r75_in = 0; r65_in = 0; r55_in = 0; gen_in = 0;
        cfg_we = 1; cfg_clr75 = 1; ie_clr = 1; step();
        cfg_we = 0; cfg_clr75 = 0; ie_clr = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); step(); step();
        rst_n = 1; step();

        // R10: reset state
        chk("R10 ie_flag", int'(ie_flag), 0);
        chk_result("R10 idle", 0);
        do_query(); gen_in = 1;
        chk("R10 masked after reset", int'(acc_valid), 0);
        gen_in = 0;

        // Exhaustive sweep: R1 R2 R5 R6 R9 over enable, masks and sources.
        for (int c = 0; c < 512; c++) begin
            automatic int  m   = c & 7;
            automatic bit  en  = c[3];
            automatic bit  p75 = c[4];
            automatic bit  l65 = c[5];
            automatic bit  l55 = c[6];
            automatic bit  g   = c[7];
            automatic bit  t   = c[8];
            automatic int  exp_src;
            cfg_mask = 3'(m);
            quiet();
            r75_in = p75; trap_in = t; step();
            r65_in = l65; r55_in = l55; gen_in = g; ie_set = en; step();
            ie_set = 0;
            do_query();
            if (t) exp_src = 1;
            else if (en && p75 && !m[2]) exp_src = 2;
            else if (en && l65 && !m[1]) exp_src = 3;
            else if (en && l55 && !m[0]) exp_src = 4;
            else if (en && g) exp_src = 5;
            else exp_src = 0;
            chk_result("R1 sweep", exp_src);
            chk("R9 ie after accept", int'(ie_flag), int'(en && exp_src == 0));
            step();
            chk("R7 pulse one cycle", int'(acc_valid), 0);
        end

        // R3: trap falls before the query -> not taken
        cfg_mask = 3'b111; quiet();
        trap_in = 1; step(); trap_in = 0; step();
        do_query();
        chk_result("R3 trap dropped", 0);

        // R3: one edge gives one acceptance even if held high
        trap_in = 1; step(); do_query();
        chk_result("R3 trap first", 1);
        step(); do_query();
        chk_result("R3 trap no repeat", 0);

        // R4: latch survives input fall and is set while masked
        quiet(); cfg_mask = 3'b111;
        r75_in = 1; step(); r75_in = 0; step();
        cfg_we = 1; cfg_mask = 3'b000; step(); cfg_we = 0;
        ie_set = 1; step(); ie_set = 0;
        do_query();
        chk_result("R4 latched R75", 2);
        ie_set = 1; step(); ie_set = 0;
        do_query();
        chk_result("R4 cleared by accept", 0);

        // R4: soft clear through the write port
        r75_in = 1; step(); r75_in = 0;
        cfg_we = 1; cfg_clr75 = 1; step(); cfg_we = 0; cfg_clr75 = 0;
        ie_set = 1; step(); ie_set = 0;
        do_query();
        chk_result("R4 soft clear", 0);

        // R4: edge in the same cycle as the soft clear wins
        cfg_we = 1; cfg_clr75 = 1; r75_in = 1; step();
        cfg_we = 0; cfg_clr75 = 0; r75_in = 0;
        do_query();
        chk_result("R4 edge beats clear", 2);

        // R7: no query, no decision even with a live request
        ie_set = 1; gen_in = 1; step(); ie_set = 0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R7 idle without query", int'(acc_valid), 0);
        end
        do_query();
        chk_result("R7 general on query", 5);

        // R9: acceptance overrides a simultaneous ie_set
        ie_set = 1; step();
        query = 1; step(); query = 0; ie_set = 0;
        chk_result("R9 accept vs set", 5);
        chk("R9 accept wins", int'(ie_flag), 0);
        ie_clr = 0; gen_in = 0;

        // R6: ie_clr disables maskable sources
        ie_set = 1; step(); ie_set = 0; ie_clr = 1; step(); ie_clr = 0;
        r65_in = 1; do_query();
        chk_result("R6 disabled", 0);
        r65_in = 0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule